// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. Its clock is the output of an external dual-modulus prescaler, which divides the oscillator signal by P or P+1 (P is 64 or 128). The block counts a frame of N prescaler periods. During the first A of those periods it asks the prescaler for P+1, and during the rest it asks for P. The oscillator therefore sees a total division of P×N+A per frame. The block emits one phase-reference pulse at each frame boundary.

The swallow count A and the main count N arrive together as one 18-bit parallel word. The block samples this word only when a frame ends, so a change made during a frame never produces a malformed frame. A status output reports settings that break the pulse-swallow arithmetic.

Top module: `psd_divider`

## Requirements
- R1: While reset is held low, `fp_pulse`, `mod_hi` and `cfg_err` are 0. The first clock edge after reset loads the word and produces no `fp_pulse`.
- R2: For N ≥ 2, `fp_pulse` is high for exactly one clock and repeats every N clocks, where N is the loaded main count.
- R3: `mod_hi` (1 = request P+1, 0 = request P) is high for the first A clocks of each frame and low for the remaining N−A clocks.
- R4: When A = 0, `mod_hi` stays low for the whole frame.
- R5: `div_word` carries A in bits 6:0 and N in bits 17:7. The block samples it only on the edge that starts a new frame, so a change made mid-frame does not affect the frame in progress.
- R6: `cfg_err` is set for the whole frame when that frame's A ≥ N or N < 16. When A ≥ N, `mod_hi` is high for the entire frame.
- R7: With a prescaler base ratio P, the oscillator cycles per frame, P×(N−A)+(P+1)×A, equal P×N+A for valid settings.
- R8: A main count of 0 or 1 gives a frame of one clock, and `fp_pulse` then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 18 | Programmed word: N in bits 17:7, A in bits 6:0 |
| mod_hi | output | 1 | Modulus request to the prescaler, 1 selects P+1 |
| fp_pulse | output | 1 | Frame-boundary pulse to the phase comparator |
| cfg_err | output | 1 | Loaded setting is outside the valid pulse-swallow range |

## Verification
The divider is run with several settings, and for each one the bench measures the pulse period and the number of P+1 requests per frame. A typical setting (A=3, N=16) checks the basic split. A=0 exposes a swallow counter that never reaches zero or starts one count late. The extreme setting (A=127, N=2047) catches truncation or wrap in either counter. Settings with A ≥ N and with N below 16 separate the error flag from normal operation. A word change part-way through a frame shows whether the block samples the word too early. N=1 covers the degenerate one-clock frame.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_W    = 7;
  localparam int N_W    = 11;
  localparam int WORD_W = A_W + N_W;
  localparam int N_MIN  = 16;

  typedef logic [A_W-1:0]    swl_t;
  typedef logic [N_W-1:0]    mainc_t;
  typedef logic [WORD_W-1:0] word_t;

  // swallow count sits in the low bits of the word
  function automatic swl_t word_a(word_t w);
    return w[A_W-1:0];
  endfunction

  // main count sits above it
  function automatic mainc_t word_n(word_t w);
    return w[WORD_W-1:A_W];
  endfunction

  // a setting is unusable when the swallow phase cannot fit in the frame
  function automatic logic cfg_bad(swl_t a, mainc_t n);
    mainc_t a_ext;
    a_ext = mainc_t'(a);
    return (a_ext >= n) || (n < mainc_t'(N_MIN));
  endfunction
endpackage

// File: rtl/psd_main_cnt.sv
module psd_main_cnt #(
  parameter int N_W = psd_pkg::N_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_val,
  output logic           reload,
  output logic           fp_pulse
);
  logic [N_W-1:0] n_rem;
  logic           primed;
  logic           last_prd;

  // current prescaler period is the final one of the frame
  assign last_prd = (n_rem <= N_W'(1));
  assign reload   = last_prd || !primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_rem    <= '0;
      primed   <= 1'b0;
      fp_pulse <= 1'b0;
    end else begin
      primed   <= 1'b1;
      fp_pulse <= primed && last_prd;
      if (reload) n_rem <= n_val;
      else        n_rem <= n_rem - N_W'(1);
    end
  end

  AST_N_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> n_rem == ($past(n_rem) - N_W'(1)));  // R2
  AST_FP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_pulse && n_rem > N_W'(1)) |=> !fp_pulse);  // R2
  AST_NO_FIRST_FP: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !fp_pulse);  // R1
endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
  parameter int A_W = psd_pkg::A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_val,
  output logic           mod_hi
);
  logic [A_W-1:0] a_rem;
  logic           swl_done;

  assign swl_done = (a_rem == '0);
  assign mod_hi   = !swl_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         a_rem <= '0;
    else if (load)      a_rem <= a_val;
    else if (!swl_done) a_rem <= a_rem - A_W'(1);
  end

  AST_A_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_hi && !load) |=> a_rem == ($past(a_rem) - A_W'(1)));  // R3
  AST_MOD_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_hi && !load) |=> !mod_hi);  // R4
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] div_word,
  output logic              mod_hi,
  output logic              fp_pulse,
  output logic              cfg_err
);
  logic   reload;
  swl_t   a_in;
  mainc_t n_in;

  assign a_in = word_a(div_word);
  assign n_in = word_n(div_word);

  psd_main_cnt #(.N_W(N_W)) u_main (
    .clk(clk), .rst_n(rst_n), .n_val(n_in),
    .reload(reload), .fp_pulse(fp_pulse)
  );

  psd_swallow_cnt #(.A_W(A_W)) u_swl (
    .clk(clk), .rst_n(rst_n), .load(reload),
    .a_val(a_in), .mod_hi(mod_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_err <= 1'b0;
    else if (reload) cfg_err <= cfg_bad(a_in, n_in);
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(cfg_err));  // R6
  AST_FRAME_ERR_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && (mainc_t'(a_in) >= n_in) && n_in != '0) |=> mod_hi);  // R6
endmodule

// File: tb/psd_divider_tb.sv
module psd_divider_tb;
  localparam int P_BASE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] div_word = '0;
  logic        mod_hi, fp_pulse, cfg_err;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  psd_divider u_dut (
    .clk(clk), .rst_n(rst_n), .div_word(div_word),
    .mod_hi(mod_hi), .fp_pulse(fp_pulse), .cfg_err(cfg_err)
  );

  function automatic logic [17:0] pack(int a, int n);
    logic [17:0] w;
    w[6:0]  = 7'(a);
    w[17:7] = 11'(n);
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fp();
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!fp_pulse && lim < 5000);
  endtask

  // from a frame-start sample, count the frame; optionally change the word at sample 3
  task automatic measure(input bit chg, input logic [17:0] w2,
                         output int per, output int mods, output int errs);
    per = 0; mods = 0; errs = 0;
    do begin
      if (mod_hi) mods++;
      if (cfg_err) errs++;
      per++;
      if (chg && per == 3) div_word = w2;
      @(negedge clk);
    end while (!fp_pulse && per < 5000);
  endtask

  task automatic run_setting(string tag, int a, int n, int exp_mods, bit exp_err);
    int per, mods, errs;
    div_word = pack(a, n);
    wait_fp();
    measure(1'b0, '0, per, mods, errs);
    chk({tag, " R2 period"}, per, n);
    chk({tag, " R3 P+1 count"}, mods, exp_mods);
    chk({tag, " R6 err frames"}, errs, exp_err ? per : 0);
    if (!exp_err)
      chk({tag, " R7 ratio"}, P_BASE * (per - mods) + (P_BASE + 1) * mods, P_BASE * n + a);
  endtask

  task automatic t_reset();
    div_word = pack(3, 16);
    repeat (3) @(negedge clk);
    chk("R1 fp in reset", int'(fp_pulse), 0);
    chk("R1 mod in reset", int'(mod_hi), 0);
    chk("R1 err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no fp on first edge", int'(fp_pulse), 0);
    chk("R5 word loaded on first edge", int'(mod_hi), 1);
  endtask

  task automatic t_midframe();
    int per, mods, errs;
    div_word = pack(5, 24);
    wait_fp();
    measure(1'b1, pack(9, 30), per, mods, errs);
    chk("R5 old frame period", per, 24);
    chk("R5 old frame P+1 count", mods, 5);
    measure(1'b0, '0, per, mods, errs);
    chk("R5 new frame period", per, 30);
    chk("R5 new frame P+1 count", mods, 9);
  endtask

  task automatic t_unit_frame();
    div_word = pack(0, 1);
    wait_fp();
    wait_fp();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 fp held for N=1", int'(fp_pulse), 1);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_setting("basic", 3, 16, 3, 1'b0);
    run_setting("R4 zero swallow", 0, 20, 0, 1'b0);
    run_setting("max", 127, 2047, 127, 1'b0);
    run_setting("mid", 50, 300, 50, 1'b0);
    run_setting("R6 A>=N", 40, 32, 32, 1'b1);
    run_setting("R6 small N", 2, 10, 2, 1'b1);
    t_midframe();
    t_unit_frame();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule